// File: doc/BRIEF.md
# SDRAM Burst Access Command Sequencer

This block converts one read or write request into the complete command sequence that a four-bank synchronous DRAM needs for one burst. A request arrives on a valid/ready handshake with a linear word address and a direction bit. The block splits the address into bank, row and column fields. It then drives a sequence of commands onto the memory pins:

- It opens the row with an ACTIVE command.
- After a parameterized activate-to-command delay, it issues READ or WRITE carrying the starting column.
- Once the burst and its read-latency or write-recovery margin have elapsed, it closes that one bank with an explicit PRECHARGE.
- After the precharge time, it returns to idle.

Row and column share the same address pins and are sent in two separate commands of the same burst. Auto-precharge is never requested, because the column-phase A10 pin is always held low. A geometry parameter selects the row and column widths:

| GEOM | Row bits | Column bits |
|------|----------|-------------|
| 0 | 12 | 10 |
| 1 | 12 | 11 |
| 2 | 13 | 11 |

All outputs come from registers and change only after a rising clock edge. A new request is taken only while the block is idle. One burst therefore owns the device from ACTIVE until its precharge time has expired.

Top module: `sdram_burst_seq`

## Requirements
- R1: During and right after reset, req_ready is 1, the command pins show NOP, and sd_ba and sd_addr are 0. NOP is {cs_n,ras_n,cas_n,we_n} = 0111.
- R2: The linear address is laid out as {row, bank, col} with col in the least significant bits. The bank field is 2 bits wide. With GEOM=1 this means col = addr[10:0], bank = addr[12:11] and row = addr[24:13].
- R3: In the cycle after a request is accepted (req_valid and req_ready both high at a rising edge), the block issues ACTIVE. ACTIVE is encoded 0011. It carries sd_ba = bank and sd_addr[ROW_W-1:0] = row, with the higher address pins at 0.
- R4: READ (0101) or WRITE (0100) appears exactly T_RCD cycles after ACTIVE, and every cycle between the two is NOP.
- R5: During READ/WRITE the block drives sd_ba = bank and sd_addr[9:0] = col[9:0], with A10 at 0. A11 carries col[10] when the column is 11 bits wide and is 0 otherwise. A12 is 0.
- R6: PRECHARGE (0010) follows READ by BURST_LEN+CAS_LAT cycles and WRITE by BURST_LEN+T_WR cycles. It carries sd_ba = bank and drives all address pins, A10 included, to 0, so only that one bank closes.
- R7: req_ready is 0 from the cycle after acceptance until exactly T_RP cycles after PRECHARGE, when it returns to 1.
- R8: req_valid while req_ready is 0 has no effect: no extra command appears, and the burst in progress keeps its bank, row, column and direction.
- R9: In every cycle without a command, the pins show NOP with sd_ba and sd_addr at 0.
- R10: A request held valid across the return to idle is accepted in the first cycle req_ready is 1, so its ACTIVE comes one cycle after req_ready rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | LIN_W (25 at GEOM=1) | Linear address {row, bank, col} |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column address pins |

## Verification
The end of one burst and the start of the next can fall in the same cycle: the cycle in which req_ready returns to 1 is also the cycle a waiting request is accepted. The bench provokes this case by keeping req_valid high through the busy period and then presenting the next request, which holds different fields than the ignored ones, exactly at the ready edge. The scoreboard judges the case by checking two things:
- the old precharge and the new ACTIVE each land on their predicted cycle;
- no command belongs to the values that were presented while the block was busy.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    localparam int PIN_W  = 13;
    localparam int BANK_W = 2;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RCD,
        ST_BURST,
        ST_RP
    } state_e;

    function automatic int row_bits(input int geom);
        return (geom == 2) ? 13 : 12;
    endfunction

    function automatic int col_bits(input int geom);
        return (geom == 0) ? 10 : 11;
    endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split
    import sdram_burst_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 11,
    localparam int LIN_W = ROW_W + BANK_W + COL_W
) (
    input  logic [LIN_W-1:0]  lin_addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    // Linear layout {row, bank, col}: consecutive columns stay in one row.
    assign col  = lin_addr[COL_W-1:0];
    assign bank = lin_addr[COL_W+BANK_W-1:COL_W];
    assign row  = lin_addr[LIN_W-1:COL_W+BANK_W];

endmodule

// File: rtl/sdram_pin_mux.sv
module sdram_pin_mux
    import sdram_burst_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 11
) (
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [PIN_W-1:0]  a
);

    logic [PIN_W-1:0] row_pins;
    logic [PIN_W-1:0] col_pins;

    assign row_pins = PIN_W'(row);

    // Column phase: A10 is held low so auto-precharge is never requested.
    generate
        if (COL_W > 10) begin : g_col_wide
            assign col_pins = {{(PIN_W-12){1'b0}}, col[10], 1'b0, col[9:0]};
        end else begin : g_col_narrow
            assign col_pins = {{(PIN_W-10){1'b0}}, col[9:0]};
        end
    endgenerate

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        a     = '0;
        case (cmd)
            CMD_ACT: begin
                ras_n = 1'b0;
                ba    = bank;
                a     = row_pins;
            end
            CMD_RD: begin
                cas_n = 1'b0;
                ba    = bank;
                a     = col_pins;
            end
            CMD_WR: begin
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = bank;
                a     = col_pins;
            end
            CMD_PRE: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                ba    = bank;
                a     = '0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
#(
    parameter int GEOM      = 1,
    parameter int T_RCD     = 3,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2,
    parameter int T_WR      = 1,
    parameter int T_RP      = 3,
    localparam int ROW_W = row_bits(GEOM),
    localparam int COL_W = col_bits(GEOM),
    localparam int LIN_W = ROW_W + BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LIN_W-1:0]  req_addr,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [PIN_W-1:0]  sd_addr
);

    localparam int GAP_RD = BURST_LEN + CAS_LAT;
    localparam int GAP_WR = BURST_LEN + T_WR;
    localparam int GAP_MX = (GAP_RD > GAP_WR) ? GAP_RD : GAP_WR;
    localparam int DLY_A  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int DLY_MX = (DLY_A > GAP_MX) ? DLY_A : GAP_MX;
    localparam int CNT_W  = $clog2(DLY_MX + 1);

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        cmd_e              cmd;
    } regs_t;

    regs_t r_d, r_q;

    logic [BANK_W-1:0] sp_bank;
    logic [ROW_W-1:0]  sp_row;
    logic [COL_W-1:0]  sp_col;

    sdram_addr_split #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_split (
        .lin_addr (req_addr),
        .bank     (sp_bank),
        .row      (sp_row),
        .col      (sp_col)
    );

    // Next-state logic for the whole sequencer.
    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_RCD;
                    r_d.cmd  = CMD_ACT;
                    r_d.bank = sp_bank;
                    r_d.row  = sp_row;
                    r_d.col  = sp_col;
                    r_d.wr   = req_write;
                    r_d.cnt  = CNT_W'(T_RCD - 1);
                end
            end
            ST_RCD: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_BURST;
                    r_d.cmd = r_q.wr ? CMD_WR : CMD_RD;
                    r_d.cnt = r_q.wr ? CNT_W'(GAP_WR - 1) : CNT_W'(GAP_RD - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_BURST: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RP;
                    r_d.cmd = CMD_PRE;
                    r_d.cnt = CNT_W'(T_RP - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RP: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.bank <= '0;
            r_q.row  <= '0;
            r_q.col  <= '0;
            r_q.wr   <= 1'b0;
            r_q.cmd  <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);

    sdram_pin_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_pins (
        .cmd   (r_q.cmd),
        .bank  (r_q.bank),
        .row   (r_q.row),
        .col   (r_q.col),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .ba    (sd_ba),
        .a     (sd_addr)
    );

    // ---------------- assertions ----------------
    logic is_act, is_rw, is_pre, is_nop;
    assign is_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign is_rw  = !sd_cs_n &&  sd_ras_n && !sd_cas_n;
    assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;

    logic [7:0]        since_act_q, since_rw_q, since_pre_q;
    logic [BANK_W-1:0] act_ba_q;
    logic              rw_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act_q <= '0;
            since_rw_q  <= '0;
            since_pre_q <= '0;
            act_ba_q    <= '0;
            rw_wr_q     <= 1'b0;
        end else begin
            since_act_q <= is_act ? 8'd1 : ((since_act_q == 8'hFF) ? since_act_q : since_act_q + 8'd1);
            since_rw_q  <= is_rw  ? 8'd1 : ((since_rw_q  == 8'hFF) ? since_rw_q  : since_rw_q  + 8'd1);
            since_pre_q <= is_pre ? 8'd1 : ((since_pre_q == 8'hFF) ? since_pre_q : since_pre_q + 8'd1);
            if (is_act) act_ba_q <= sd_ba;
            if (is_rw)  rw_wr_q  <= !sd_we_n;
        end
    end

    AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> $past(req_valid && req_ready)); // R3
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> (since_act_q == 8'(T_RCD))); // R4
    AST_NO_AUTO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> (sd_addr[10] == 1'b0)); // R5
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_rw_q == (rw_wr_q ? 8'(GAP_WR) : 8'(GAP_RD)))); // R6
    AST_PRE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (sd_ba == act_ba_q && sd_addr == '0)); // R6
    AST_READY_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (since_pre_q == 8'(T_RP))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> is_nop); // R8
    AST_NOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> (sd_ba == '0 && sd_addr == '0)); // R9

endmodule

// File: tb/sdram_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_burst_seq_test;

    localparam int GEOM      = 1;
    localparam int T_RCD     = 3;
    localparam int BURST_LEN = 4;
    localparam int CAS_LAT   = 2;
    localparam int T_WR      = 1;
    localparam int T_RP      = 3;
    localparam int LIN_W     = 25;

    typedef struct {
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [12:0] addr;
        int          cyc;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [LIN_W-1:0] req_addr = '0;
    logic req_ready;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_burst_seq #(
        .GEOM      (GEOM),
        .T_RCD     (T_RCD),
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT),
        .T_WR      (T_WR),
        .T_RP      (T_RP)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Scoreboard monitor: each non-NOP cycle must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] pins;
            exp_t e;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (pins == 4'b0111) begin
                // R9: an idle cycle drives zero bank and zero address
                check(sd_ba == 2'b0 && sd_addr == 13'b0, "R9",
                      {49'b0, sd_ba, sd_addr}, 64'b0);
            end else if (q.size() == 0) begin
                // R8: no command may appear that no accepted request asked for
                check(1'b0, "R8", {47'b0, pins, sd_ba, sd_addr}, 64'b0);
            end else begin
                e = q.pop_front();
                check(pins == e.pins && sd_ba == e.ba && sd_addr == e.addr && cyc == e.cyc,
                      e.tag,
                      {cyc, 13'b0, pins, sd_ba, sd_addr},
                      {e.cyc, 13'b0, e.pins, e.ba, e.addr});
            end
        end
    end

    // Driver: called at a negedge; pushes the expected commands and follows req_ready.
    task automatic do_req(input logic wr, input logic [LIN_W-1:0] a, input bit junk_while_busy);
        exp_t e;
        logic [1:0]  bank;
        logic [11:0] row;
        logic [10:0] col;
        logic [12:0] colp;
        int t_act, t_rw, t_pre, t_rdy;
        while (!req_ready) @(negedge clk);
        // R2: {row, bank, col}
        col  = a[10:0];
        bank = a[12:11];
        row  = a[24:13];
        colp = {1'b0, col[10], 1'b0, col[9:0]};
        t_act = cyc + 1;
        t_rw  = t_act + T_RCD;
        t_pre = t_rw + BURST_LEN + (wr ? T_WR : CAS_LAT);
        t_rdy = t_pre + T_RP;
        e.pins = 4'b0011; e.ba = bank; e.addr = {1'b0, row}; e.cyc = t_act; e.tag = "R3 R2";
        q.push_back(e);
        e.pins = wr ? 4'b0100 : 4'b0101; e.ba = bank; e.addr = colp; e.cyc = t_rw; e.tag = "R4 R5";
        q.push_back(e);
        e.pins = 4'b0010; e.ba = bank; e.addr = 13'b0; e.cyc = t_pre; e.tag = "R6";
        q.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        @(negedge clk);
        if (junk_while_busy) begin
            // R8: different request presented while busy
            req_write = ~wr;
            req_addr  = ~a;
        end else begin
            req_valid = 1'b0;
        end
        while (cyc < t_rdy) begin
            check(req_ready == 1'b0, "R7", {63'b0, req_ready}, 64'd0);
            @(negedge clk);
        end
        check(req_ready == 1'b1 && cyc == t_rdy, "R7",
              {31'b0, req_ready, cyc}, {31'b0, 1'b1, t_rdy});
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 20000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is still applied
        check(req_ready == 1'b1, "R1", {63'b0, req_ready}, 64'd1);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && sd_ba == 2'b0 && sd_addr == 13'b0,
              "R1", {47'b0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr}, {47'b0, 4'b0111, 15'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", {63'b0, req_ready}, 64'd1);
        repeat (2) @(negedge clk);

        do_req(1'b0, 25'h0, 1'b0);
        repeat (3) @(negedge clk);
        do_req(1'b1, {LIN_W{1'b1}}, 1'b0);
        // R10: back-to-back requests, accepted at the first ready cycle
        do_req(1'b0, {12'hABC, 2'b10, 11'h400}, 1'b0);
        do_req(1'b1, {12'h123, 2'b01, 11'h3FF}, 1'b0);
        // R8: junk held valid while busy, then R10 with the next request on the ready edge
        do_req(1'b1, {12'h5A5, 2'b11, 11'h2AA}, 1'b1);
        do_req(1'b0, {12'h800, 2'b00, 11'h555}, 1'b1);
        do_req(1'b1, {12'h001, 2'b10, 11'h001}, 1'b0);
        repeat (5) @(negedge clk);
        do_req(1'b0, {12'hFFF, 2'b01, 11'h7FE}, 1'b0);
        repeat (10) @(negedge clk);
        // R8: nothing may be left outstanding and nothing extra issued
        check(q.size() == 0, "R8", q.size(), 0);
        finish_run();
    end

endmodule